// File: doc/BRIEF.md
# Dual-Protocol Parallel Host Bus Bridge

This block sits between an external 8-bit microprocessor bus and an internal file of 64 byte-wide registers. One mode input selects the strobe style. In Intel style there are separate active-low read and write strobes. In Motorola style there is a read/write level plus an active-low data strobe. A second mode input selects a multiplexed bus or a nonmultiplexed one. On a multiplexed bus the address travels on the low data lines under an address strobe. On a nonmultiplexed bus a separate 6-bit address bus is used.

All external strobes are oversampled by the system clock through two synchronizing flops, and the bridge acts on the detected edges. Each write strobe becomes one single-cycle internal write pulse, carrying the latched address and the captured byte. Each read strobe becomes one single-cycle read request. The bridge registers the returned byte and drives it on the data bus while the read strobe is active. Both mode inputs are treated as static while the bus is idle.

Top module: `host_bus_bridge`

## Requirements
- R1: After reset, `reg_we_o`, `reg_re_o` and `data_oe_o` are low.
- R2: In Intel multiplexed mode (`motorola_i`=0, `muxed_i`=1), the register address is taken from `data_i[5:0]`, sampled just before the falling edge of `addr_stb_i`, which acts as an active-high latch enable.
- R3: In Motorola multiplexed mode (`motorola_i`=1, `muxed_i`=1), the address is taken from `data_i[5:0]`, sampled just before the falling edge of `addr_stb_i`, which acts as an active-low address strobe.
- R4: In nonmultiplexed mode (`muxed_i`=0), the address is taken from `addr_i`, sampled just before the falling edge of the access strobe. The access strobe is `rd_rw_i` or `wr_ds_i` in Intel mode and `wr_ds_i` in Motorola mode. Edges on `addr_stb_i` are ignored, and in multiplexed mode `addr_i` is ignored.
- R5: Every write strobe produces exactly one `reg_we_o` pulse of one cycle. The pulse carries the data byte last sampled before the strobe's rising edge. In Intel mode the write strobe is `wr_ds_i` low.
- R6: In Motorola mode, a `wr_ds_i` low period with `rd_rw_i`=0 is a write and one with `rd_rw_i`=1 is a read.
- R7: Every read strobe produces exactly one `reg_re_o` pulse of one cycle at the latched address. The returned byte appears on `data_o` no later than the fifth rising clock edge after the strobe falls. In Intel mode the read strobe is `rd_rw_i` low.
- R8: `data_oe_o` is high only while a read strobe is active. It drops combinationally, in the same cycle, when the raw read strobe deasserts, and it stays low throughout write accesses.
- R9: Reads have no side effect: no `reg_we_o` pulse results from a read access.
- R10: `reg_we_o` and `reg_re_o` are never high in the same cycle. When a write's end and a read's start are detected together, the write is issued first at the old address and the read follows at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| motorola_i | input | 1 | 1: R/W plus data strobe, 0: separate read and write strobes |
| muxed_i | input | 1 | 1: address on data lines, 0: separate address bus |
| addr_stb_i | input | 1 | Address latch strobe (falling edge latches) |
| rd_rw_i | input | 1 | Intel read strobe (low) / Motorola read-high write-low |
| wr_ds_i | input | 1 | Intel write strobe / Motorola data strobe, active low |
| addr_i | input | 6 | Nonmultiplexed address bus |
| data_i | input | 8 | Data (and multiplexed address) bus input |
| data_o | output | 8 | Read data to the bus |
| data_oe_o | output | 1 | Bus output driver enable |
| reg_we_o | output | 1 | Internal write pulse |
| reg_re_o | output | 1 | Internal read request |
| reg_addr_o | output | 6 | Internal register address |
| reg_wdata_o | output | 8 | Internal write data |
| reg_rdata_i | input | 8 | Internal read data, valid with `reg_re_o` |

## Verification
Two events can be detected in the same cycle: the rising edge that ends a write and the falling edge that starts the next access. In nonmultiplexed Intel mode, that next access also latches a new address. The bench provokes this by raising the write strobe and dropping the read strobe at the same instant, with the new address already on `addr_i`. It judges the result by three things: the write pulse lands at the old address with its byte, the read request is kept in a separate cycle, and the byte returned for the new address appears on `data_o`.

// File: rtl/host_bus_pkg.sv
package host_bus_pkg;
  // strobe bit positions inside the synchronized vector
  localparam int STB_AS = 0;
  localparam int STB_RR = 1;
  localparam int STB_WD = 2;
  localparam int STB_N  = 3;

  typedef struct packed {
    logic read_go;    // read access starts
    logic write_go;   // write access ends, commit
    logic acc_start;  // access strobe fell (nonmux address sample)
    logic alat;       // multiplexed address latch edge
    logic rd_act;     // synchronized read strobe active
  } hb_evt_t;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int           W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,   // second stage: synchronized value
  output logic [W-1:0] qd_o   // third stage: previous synchronized value
);
  localparam int DEPTH = 3;
  logic [W-1:0] st [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     st[k] <= RST;
      else if (k == 0) st[k] <= d_i;
      else             st[k] <= st[(k > 0) ? k - 1 : 0];
    end
  end

  assign q_o  = st[DEPTH-2];
  assign qd_o = st[DEPTH-1];
endmodule

// File: rtl/hb_decode.sv
module hb_decode
  import host_bus_pkg::*;
(
  input  logic             motorola_i,
  input  logic             muxed_i,
  input  logic [STB_N-1:0] s_cur_i,
  input  logic [STB_N-1:0] s_prev_i,
  input  logic             rd_rw_raw_i,
  input  logic             wr_ds_raw_i,
  output hb_evt_t          evt_o,
  output logic             oe_o
);
  logic [STB_N-1:0] fall, rise;
  assign fall = s_prev_i & ~s_cur_i;
  assign rise = ~s_prev_i & s_cur_i;

  always_comb begin
    evt_o      = '0;
    evt_o.alat = muxed_i & fall[STB_AS];
    if (motorola_i) begin
      evt_o.read_go   = fall[STB_WD] & s_cur_i[STB_RR];
      evt_o.write_go  = rise[STB_WD] & ~s_prev_i[STB_RR];
      evt_o.acc_start = ~muxed_i & fall[STB_WD];
      evt_o.rd_act    = ~s_cur_i[STB_WD] & s_cur_i[STB_RR];
      oe_o            = evt_o.rd_act & ~wr_ds_raw_i & rd_rw_raw_i;
    end else begin
      evt_o.read_go   = fall[STB_RR];
      evt_o.write_go  = rise[STB_WD];
      evt_o.acc_start = ~muxed_i & (fall[STB_RR] | fall[STB_WD]);
      evt_o.rd_act    = ~s_cur_i[STB_RR];
      oe_o            = evt_o.rd_act & ~rd_rw_raw_i;
    end
  end
endmodule

// File: rtl/host_bus_bridge.sv
module host_bus_bridge
  import host_bus_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              motorola_i,
  input  logic              muxed_i,
  input  logic              addr_stb_i,
  input  logic              rd_rw_i,
  input  logic              wr_ds_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [STB_N-1:0] s_cur, s_prev;
  logic [BUS_W-1:0] bus_cur, bus_prev;
  logic [ADDR_W-1:0] bus_addr, addr_q, eff_addr;
  logic [DATA_W-1:0] bus_data;
  hb_evt_t evt;
  logic defer_q, we_q, re_q;

  hb_sync #(.W(STB_N), .RST('1)) u_stb_sync (
    .clk_i, .rst_ni,
    .d_i  ({wr_ds_i, rd_rw_i, addr_stb_i}),
    .q_o  (s_cur),
    .qd_o (s_prev)
  );

  // bus travels alongside strobes; prev stage is the last sample before an edge
  hb_sync #(.W(BUS_W), .RST('0)) u_bus_sync (
    .clk_i, .rst_ni,
    .d_i  ({addr_i, data_i}),
    .q_o  (bus_cur),
    .qd_o (bus_prev)
  );

  assign bus_addr = bus_prev[BUS_W-1 -: ADDR_W];
  assign bus_data = bus_prev[DATA_W-1:0];

  hb_decode u_decode (
    .motorola_i, .muxed_i,
    .s_cur_i     (s_cur),
    .s_prev_i    (s_prev),
    .rd_rw_raw_i (rd_rw_i),
    .wr_ds_raw_i (wr_ds_i),
    .evt_o       (evt),
    .oe_o        (data_oe_o)
  );

  assign eff_addr = evt.acc_start ? bus_addr : addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (evt.alat) begin
      addr_q <= bus_data[ADDR_W-1:0];
    end else if (evt.acc_start) begin
      addr_q <= bus_addr;
    end
  end

  // write wins a collision; a read detected together with it is issued next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q        <= 1'b0;
      re_q        <= 1'b0;
      defer_q     <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      data_o      <= '0;
    end else begin
      we_q    <= evt.write_go;
      re_q    <= (evt.read_go & ~evt.write_go) | defer_q;
      defer_q <= evt.read_go & evt.write_go;
      if (evt.write_go) begin
        reg_addr_o  <= addr_q;
        reg_wdata_o <= bus_data;
      end else if (evt.read_go) begin
        reg_addr_o  <= eff_addr;
      end else if (defer_q) begin
        reg_addr_o  <= addr_q;
      end
      if (re_q) data_o <= reg_rdata_i;
    end
  end

  assign reg_we_o = we_q;
  assign reg_re_o = re_q;

  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R5
  AST_RE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o); // R7
  AST_NO_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o)); // R10
  AST_OE_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (motorola_i ? (rd_rw_i && !wr_ds_i) : !rd_rw_i)); // R8
  AST_RE_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> $stable(reg_addr_o) || reg_we_o); // R7
endmodule

// File: tb/host_bus_bridge_bench.sv
`timescale 1ns/1ps
module host_bus_bridge_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic moto = 1'b0, muxed = 1'b0, as = 1'b1, rr = 1'b1, wd = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] data = '0;
  logic [7:0] dout, wdata, rdata;
  logic oe, we, re;
  logic [5:0] raddr;
  logic [7:0] mem [64];
  int checks = 0, errors = 0;
  int we_cnt = 0, re_cnt = 0;
  logic [5:0] last_wa;
  logic [7:0] last_wd;
  bit done = 0;

  always #2 clk = ~clk;

  host_bus_bridge u_host_bus_bridge (
    .clk_i(clk), .rst_ni(rst_n), .motorola_i(moto), .muxed_i(muxed),
    .addr_stb_i(as), .rd_rw_i(rr), .wr_ds_i(wd), .addr_i(addr), .data_i(data),
    .data_o(dout), .data_oe_o(oe), .reg_we_o(we), .reg_re_o(re),
    .reg_addr_o(raddr), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  assign rdata = mem[raddr];

  always @(posedge clk) begin
    if (rst_n && we) begin
      mem[raddr] <= wdata; we_cnt <= we_cnt + 1; last_wa <= raddr; last_wd <= wdata;
    end
    if (rst_n && re) re_cnt <= re_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // multiplexed address phase: address on data lines, then falling strobe
  task automatic addr_phase(input logic [5:0] a);
    data = {2'b00, a};
    if (!moto) as = 1'b1;
    cyc(3);
    as = 1'b0;
    cyc(2);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [7:0] d, input string req);
    int w0 = we_cnt;
    int r0 = re_cnt;
    if (muxed) addr_phase(a); else addr = a;
    data = d;
    if (moto) rr = 1'b0;
    cyc(1);
    wd = 1'b0;
    cyc(3);
    chk(oe == 1'b0, "R8 oe during write", oe, 0);
    cyc(1);
    wd = 1'b1;
    cyc(1);
    rr = 1'b1;
    cyc(4);
    if (moto && muxed) as = 1'b1;
    chk(we_cnt == w0 + 1, {req, " write pulse count"}, we_cnt - w0, 1);
    chk(last_wa == a, {req, " write addr"}, last_wa, a);
    chk(last_wd == d, {req, " write data"}, last_wd, d);
    chk(re_cnt == r0, "R6 no read on write", re_cnt - r0, 0);
  endtask

  task automatic do_read(input logic [5:0] a, input string req);
    int w0 = we_cnt;
    int r0 = re_cnt;
    logic [7:0] exp = mem[a];
    if (muxed) addr_phase(a); else addr = a;
    if (moto) rr = 1'b1;
    cyc(1);
    if (moto) wd = 1'b0; else rr = 1'b0;
    cyc(6);
    chk(oe == 1'b1, "R8 oe during read", oe, 1);
    chk(dout == exp, {req, " read data"}, dout, exp);
    chk(re_cnt == r0 + 1, "R7 read request count", re_cnt - r0, 1);
    if (moto) wd = 1'b1; else rr = 1'b1;
    #0.5;
    chk(oe == 1'b0, "R8 oe release", oe, 0);
    cyc(4);
    if (moto && muxed) as = 1'b1;
    chk(we_cnt == w0, "R9 read has no write", we_cnt - w0, 0);
    chk(re_cnt == r0 + 1, "R7 single read request", re_cnt - r0, 1);
  endtask

  task automatic t_reset;
    chk(we == 0 && re == 0 && oe == 0, "R1 reset outputs", {we, re, oe}, 0);
  endtask

  task automatic t_intel_nonmux;
    moto = 0; muxed = 0; as = 1'b1; cyc(3);
    do_write(6'd0, 8'hA5, "R4 R5 intel nonmux");
    do_write(6'd63, 8'h3C, "R4 R5 intel nonmux");
    do_read(6'd0, "R4 R7");
    do_read(6'd63, "R4 R7");
  endtask

  task automatic t_intel_mux;
    moto = 0; muxed = 1; as = 1'b0; addr = 6'd9; cyc(3);
    do_write(6'd21, 8'h77, "R2 intel mux");
    do_read(6'd21, "R2 intel mux");
    chk(mem[9] != 8'h77, "R4 addr_i ignored in mux", mem[9], 0);
  endtask

  task automatic t_moto_mux;
    moto = 1; muxed = 1; as = 1'b1; cyc(3);
    do_write(6'd42, 8'hC3, "R3 R6 moto mux");
    do_read(6'd42, "R3 R6 moto mux");
  endtask

  task automatic t_moto_nonmux;
    moto = 1; muxed = 0; as = 1'b1; cyc(3);
    do_write(6'd5, 8'h12, "R4 R6 moto nonmux");
    // address strobe edge with other address on data lines must be ignored
    data = 8'h07; as = 1'b0; cyc(3); as = 1'b1; cyc(2);
    do_read(6'd5, "R4 R6 moto nonmux");
  endtask

  task automatic t_late_data;
    int w0;
    moto = 0; muxed = 0; cyc(3);
    w0 = we_cnt;
    addr = 6'd30; data = 8'h11; cyc(1);
    wd = 1'b0; cyc(4);
    wd = 1'b1; data = 8'hEE; // value after the edge must not be captured
    cyc(5);
    chk(we_cnt == w0 + 1, "R5 single pulse", we_cnt - w0, 1);
    chk(last_wd == 8'h11, "R5 data before rise", last_wd, 8'h11);
  endtask

  task automatic t_collide;
    int w0, r0;
    moto = 0; muxed = 0; cyc(3);
    w0 = we_cnt; r0 = re_cnt;
    addr = 6'd50; data = 8'h9D; cyc(1);
    wd = 1'b0; cyc(2);
    addr = 6'd33; cyc(2);
    wd = 1'b1; rr = 1'b0;
    cyc(7);
    chk(dout == mem[33], "R10 read at new address", dout, mem[33]);
    rr = 1'b1; cyc(4);
    chk(we_cnt == w0 + 1 && last_wa == 6'd50, "R10 write at old address", last_wa, 50);
    chk(last_wd == 8'h9D, "R10 write data", last_wd, 8'h9D);
    chk(re_cnt == r0 + 1, "R10 read issued", re_cnt - r0, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i) ^ 8'h5A;
    cyc(3);
    t_reset;
    rst_n = 1'b1;
    cyc(4);
    t_intel_nonmux;
    t_intel_mux;
    t_moto_mux;
    t_moto_nonmux;
    t_late_data;
    t_collide;
    finish_run;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run;
  end
endmodule